// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that exposes a small bank of configuration bytes. These bytes drive output enables and similar device controls as parallel signals. Every register loads a default value at reset, so a system that never talks to the block still gets a working configuration. The serial interface is only needed to change that configuration, normally once during bring-up.

The block takes SCL and SDA as plain inputs sampled by a system clock that is much faster than the bus. It resynchronises both lines and detects start, stop and clock edges inside the system clock domain. It never drives SDA high. It only raises `sda_pull` to pull the line low through an external open-drain pad.

The first byte after the slave address is a command byte. If bit 7 of that byte is set, bits 6:0 give the offset of a single register to access. If bit 7 is clear, the command selects a block transfer, which always begins at register 0 and moves upward.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte D2h for writes and D3h for reads: the 7-bit address is 69h and bit 0 is the read/write flag. Any other address byte gets no acknowledge, and the slave ignores the rest of that transaction.
- R2: A command byte with bit 7 = 1 selects byte access, with the offset in bits 6:0. The data byte that follows is written to that offset, and the new value appears on `regs_out` (register i occupies bits 8i+7:8i).
- R3: A byte read returns the register at the commanded offset, most significant bit first. The read is a repeated start followed by D3h.
- R4: A command byte with bit 7 = 0 selects block access. On a write, the next byte is a byte count, which is acknowledged but not stored. The data bytes that follow fill registers 0, 1, 2 and upward in order.
- R5: A block read first returns the byte count, which equals the bank size (8). It then returns registers 0, 1, 2 and upward, for as long as the master acknowledges.
- R6: A block write that the master ends with a stop after any complete byte changes only the registers already sent. All other registers keep their values.
- R7: Offsets 8 and above are acknowledged. Writes to them leave every register unchanged, and reads from them return FFh.
- R8: After each byte it receives, the slave pulls SDA low during the ninth clock. During a read it releases SDA for the ninth clock. A master NACK ends the read, and SDA then stays released.
- R9: A stop returns the slave to idle at any point. A repeated start returns it to address matching. A transaction cut short after the command byte writes nothing.
- R10: After reset, `regs_out` equals the DEFAULTS parameter and `sda_pull` is low.
- R11: The slave starts pulling SDA low only in response to SCL being low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | When high, the pad pulls SDA low |
| regs_out | output | NREG*8 | Register bank, register i in bits 8i+7:8i |

## Verification
The hardest case to reach is the ninth-clock handoff during a read. At that point SDA ownership passes from slave to master and back, and a NACK must leave the line free for the stop that follows. The bench drives a master model with a pull-up wired-AND bus and reads with random lengths, so the last byte, which gets the NACK, may fall on the count byte, on a data byte, or past the end of the bank. It also stops block writes after a random number of bytes and combines them with out-of-range offsets and foreign addresses. The register model can therefore tell partial writes apart from discarded ones.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int NREG = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] DEFAULTS = 64'h0FF05AA5C33C817E
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_pull,
  output logic [NREG*8-1:0] regs_out
);

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [7:0] COUNT_BYTE = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD} state_t;

  logic [2:0] scl_q, sda_q;
  logic [7:0] mem [NREG];
  state_t     st;
  logic [3:0] bitcnt;
  logic       ackclk, mack, blk, cnt_ph;
  logic [7:0] shreg, txb;
  logic [6:0] ptr;

  wire scl = scl_q[1];
  wire sda = sda_q[1];
  wire scl_rise = scl & ~scl_q[2];
  wire scl_fall = ~scl & scl_q[2];
  wire start_det = scl & scl_q[2] & sda_q[2] & ~sda;
  wire stop_det  = scl & scl_q[2] & ~sda_q[2] & sda;
  wire in_rng = ptr < 7'(NREG);
  wire [IW-1:0] idx = ptr[IW-1:0];
  wire [7:0] rd_val = in_rng ? mem[idx] : 8'hFF;
  wire [7:0] next_tx = cnt_ph ? COUNT_BYTE : rd_val;
  wire [6:0] ptr_inc = (ptr == 7'h7F) ? ptr : ptr + 7'd1;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_out[g*8 +: 8] = mem[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      ackclk   <= 1'b0;
      mack     <= 1'b0;
      blk      <= 1'b0;
      cnt_ph   <= 1'b0;
      shreg    <= '0;
      txb      <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= DEFAULTS[i*8 +: 8];
    end else if (start_det) begin
      st       <= S_ADDR;
      bitcnt   <= '0;
      ackclk   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end else begin
          ackclk <= 1'b1;
          mack   <= ~sda;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8 && !ackclk) begin
          case (st)
            S_ADDR: begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                if (shreg[0]) begin
                  st     <= S_RD;
                  cnt_ph <= blk;
                end else begin
                  st <= S_CMD;
                end
              end else begin
                st <= S_IDLE;
              end
            end
            S_CMD: begin
              sda_pull <= 1'b1;
              blk      <= ~shreg[7];
              ptr      <= shreg[7] ? shreg[6:0] : 7'd0;
              st       <= shreg[7] ? S_WR : S_CNT;
            end
            S_CNT: begin
              sda_pull <= 1'b1;
              st       <= S_WR;
            end
            S_WR: begin
              sda_pull <= 1'b1;
              if (in_rng) mem[idx] <= shreg;
              ptr <= ptr_inc;
            end
            default: sda_pull <= 1'b0;
          endcase
        end else if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          ackclk <= 1'b0;
          if (st == S_RD) begin
            if (mack) begin
              txb      <= next_tx;
              sda_pull <= ~next_tx[7];
              if (cnt_ph) cnt_ph <= 1'b0;
              else ptr <= ptr_inc;
            end else begin
              st       <= S_IDLE;
              sda_pull <= 1'b0;
            end
          end else begin
            sda_pull <= 1'b0;
          end
        end else if (st == S_RD && bitcnt != 4'd0) begin
          sda_pull <= ~txb[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull);

  p_pull_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !$past(scl));

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_pull));

  p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && bitcnt == 4'd0));

  p_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_out) |-> $past(st) == S_WR);

  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);

endmodule

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;
  localparam int Q = 6;
  localparam logic [63:0] DEF = 64'h0FF05AA5C33C817E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic [63:0] regs_out;
  logic sda_line;
  int total = 0;
  int bad = 0;
  logic [7:0] model [8];

  assign sda_line = m_sda & ~sda_pull;

  always #2 clk = ~clk;

  smb_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .regs_out(regs_out)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] packed_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] model_rd(input int off);
    return (off < 8) ? model[off] : 8'hFF;
  endfunction

  task automatic start_c();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); m_scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      tick(Q); m_scl = 1'b0;
    end
    m_sda = ~give_ack; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic byte_write(input int off, input logic [7:0] d);
    logic a;
    start_c();
    wbyte(8'hD2, a); chk(a, "R1 addr ack", 64'(a), 64'd1);
    wbyte(8'h80 | 8'(off), a); chk(a, "R8 cmd ack", 64'(a), 64'd1);
    wbyte(d, a); chk(a, "R7/R8 data ack", 64'(a), 64'd1);
    stop_c();
    if (off < 8) model[off] = d;
    tick(4);
    chk(regs_out == packed_model(), "R2/R7 byte write", regs_out, packed_model());
  endtask

  task automatic byte_read(input int off);
    logic a;
    logic [7:0] d;
    start_c();
    wbyte(8'hD2, a);
    wbyte(8'h80 | 8'(off), a);
    start_c();
    wbyte(8'hD3, a); chk(a, "R1 read addr ack", 64'(a), 64'd1);
    rbyte(1'b0, d);
    chk(d == model_rd(off), "R3/R7 byte read", 64'(d), 64'(model_rd(off)));
    tick(Q);
    chk(sda_line == 1'b1, "R8 release after nack", 64'(sda_line), 64'd1);
    stop_c();
  endtask

  task automatic block_write(input int n, input logic [7:0] seed);
    logic a;
    logic [7:0] d;
    start_c();
    wbyte(8'hD2, a);
    wbyte(8'h00, a);
    wbyte(8'(n), a); chk(a, "R4 count ack", 64'(a), 64'd1);
    for (int i = 0; i < n; i++) begin
      d = seed ^ 8'(i * 37);
      wbyte(d, a);
      if (i < 8) model[i] = d;
    end
    stop_c();
    tick(4);
    chk(regs_out == packed_model(), "R4/R6 block write", regs_out, packed_model());
  endtask

  task automatic block_read(input int n);
    logic a;
    logic [7:0] d;
    start_c();
    wbyte(8'hD2, a);
    wbyte(8'h00, a);
    start_c();
    wbyte(8'hD3, a);
    rbyte(n > 0, d);
    chk(d == 8'd8, "R5 count byte", 64'(d), 64'd8);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk(d == model_rd(i), "R5/R7 block data", 64'(d), 64'(model_rd(i)));
    end
    tick(Q);
    chk(sda_line == 1'b1, "R8 release after nack", 64'(sda_line), 64'd1);
    stop_c();
  endtask

  task automatic foreign_addr(input logic [7:0] ad);
    logic a;
    start_c();
    wbyte(ad, a); chk(!a, "R1 foreign addr nack", 64'(a), 64'd0);
    wbyte(8'h81, a);
    wbyte(8'h55, a);
    stop_c();
    tick(4);
    chk(regs_out == packed_model(), "R1 foreign ignored", regs_out, packed_model());
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic a;
    int op, off, n;
    for (int i = 0; i < 8; i++) model[i] = DEF[i*8 +: 8];
    void'($urandom(32'h5EED));
    tick(5);
    chk(regs_out == DEF, "R10 reset regs", regs_out, DEF);
    chk(sda_pull == 1'b0, "R10 reset sda", 64'(sda_pull), 64'd0);
    rst_n = 1'b1;
    tick(5);

    byte_read(0);
    byte_read(7);
    byte_write(5, 8'h3D);
    byte_read(5);
    block_write(3, 8'hC6);
    block_read(8);
    byte_write(8'h40, 8'h99);
    byte_read(8'h40);
    block_write(10, 8'h12);
    block_read(10);
    block_read(0);
    foreign_addr(8'hA4);
    foreign_addr(8'hD0);

    start_c();
    wbyte(8'hD2, a);
    wbyte(8'h82, a);
    stop_c();
    tick(4);
    chk(regs_out == packed_model(), "R9 stop after cmd", regs_out, packed_model());

    start_c();
    wbyte(8'hD2, a);
    wbyte(8'h83, a);
    start_c();
    wbyte(8'hD2, a); chk(a, "R9 repeated start addr", 64'(a), 64'd1);
    wbyte(8'h81, a);
    wbyte(8'h6B, a);
    stop_c();
    model[1] = 8'h6B;
    tick(4);
    chk(regs_out == packed_model(), "R9 repeated start write", regs_out, packed_model());

    for (int k = 0; k < 30; k++) begin
      op = int'($urandom_range(0, 4));
      off = int'($urandom_range(0, 11));
      n = int'($urandom_range(1, 10));
      case (op)
        0: byte_write(off, 8'($urandom));
        1: byte_read(off);
        2: block_write(n, 8'($urandom));
        3: block_read(n);
        default: foreign_addr(8'($urandom) & 8'hFE | 8'h01 ^ 8'h01 | ((8'($urandom) == 8'hD2) ? 8'h04 : 8'h00) | 8'h20);
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule